// File: doc/BRIEF.md
# Grouped Interrupt Aggregator

This block gathers per-pin interrupt events from a bank of 8-pin ports and folds them into a small number of groups. Each group owns a fixed run of consecutive ports, so a group of four ports holds 32 event bits. Every group has three parts. The first is a sticky source register, which records events even while they are masked. The second is an enable mask, which software sets through one register and clears through another. The third is a result, which is the source ANDed with the enable. A group's interrupt line is raised only when the result is nonzero and that group's bit in a shared block-enable register is set.

Software reaches the block through a plain register bus with no back-pressure. A write is taken on any clock edge where `bus_we_i` is high. Read data is a combinational function of `bus_addr_i` and the current register state, so it is valid in the same cycle as the address. No event stream has a handshake: each pin input is sampled on every clock edge. A pin that is high at an edge marks its source bit.

Word addresses follow this layout. Group g occupies addresses 4g to 4g+3: +0 is the source, +1 is the enable-set register, +2 is the enable-clear register and +3 is the result. The block-enable register sits at address 4*NUM_GROUPS. Any other address reads as zero.

Top module: `irq_aggregator`

## Requirements
- R1: A source bit is set on the clock edge where its pin input is high. It stays set until software clears it, whether or not the bit is enabled.
- R2: Writing a 1 to a bit of a group's source register (offset +0) clears that bit, even when the bit is not enabled. Writing a 0 leaves the bit unchanged.
- R3: Writing a 1 to a bit of the enable-set register (offset +1) sets that enable bit, and zero bits leave the mask unchanged. Reading offset +1 returns the current enable mask.
- R4: Writing a 1 to a bit of the enable-clear register (offset +2) clears that enable bit. Offset +2 always reads as zero.
- R5: The result register (offset +3) reads as source AND enable.
- R6: Group interrupt `irq_o[g]` is high exactly when bit g of the block-enable register is set and group g's result is nonzero.
- R7: Pin input `pin_evt_i[(g*PORTS_PER_GROUP + p)*8 + i]` drives bit `p*8 + i` of group g, so successive ports fill successive bytes.
- R8: If a pin event and a clearing write hit the same source bit in the same cycle, the event wins and the bit stays set.
- R9: After reset every source, enable and block-enable bit is zero, every interrupt output is low, and every register reads zero.
- R10: The block-enable register at word address 4*NUM_GROUPS is written in full and reads back its value. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_evt_i | input | NUM_GROUPS*PORTS_PER_GROUP*8 | Per-pin event inputs, sampled each edge |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data |
| irq_o | output | NUM_GROUPS | Per-group interrupt lines |

## Verification
The embedded assertions check the per-cycle bit rules on every cycle:
- sticky setting and the absence of spurious source bits;
- clears that take effect unless an event collides with them;
- set and clear operations on the enable mask;
- the rule that an interrupt line needs both its block-enable bit and a nonzero result.

Only the bench scenarios can show the rest: the register address layout, that the enable-clear register reads as zero, the pin-to-bit mapping across ports and groups, and the full read-back values after a sequence of writes and events.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    OFS_SRC   = 2'd0,
    OFS_ENSET = 2'd1,
    OFS_ENCLR = 2'd2,
    OFS_RES   = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/irq_port_map.sv
`timescale 1ns/1ps
// Routes flat per-pin events into per-group event vectors (R7).
module irq_port_map #(
  parameter int NUM_GROUPS      = 4,
  parameter int PORTS_PER_GROUP = 4,
  localparam int GROUP_W  = PORTS_PER_GROUP * 8,
  localparam int NUM_PINS = NUM_GROUPS * GROUP_W
) (
  input  logic [NUM_PINS-1:0]              pin_evt_i,
  output logic [NUM_GROUPS-1:0][GROUP_W-1:0] grp_evt_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar p = 0; p < PORTS_PER_GROUP; p++) begin : g_port
      // port number = g*PORTS_PER_GROUP + p ; group offset = g*PORTS_PER_GROUP
      assign grp_evt_o[g][p*8 +: 8] = pin_evt_i[(g*PORTS_PER_GROUP + p)*8 +: 8];
    end
  end
endmodule

// File: rtl/irq_group.sv
`timescale 1ns/1ps
// One interrupt group: sticky source, set/clear enable mask, masked result.
module irq_group #(
  parameter int GROUP_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GROUP_W-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_ofs_i,
  input  logic [GROUP_W-1:0] wdata_i,
  output logic [GROUP_W-1:0] src_o,
  output logic [GROUP_W-1:0] en_o,
  output logic [GROUP_W-1:0] res_o,
  output logic               any_o
);
  import irq_agg_pkg::*;

  logic [GROUP_W-1:0] src_q, en_q;
  logic [GROUP_W-1:0] clr_w, set_w, dis_w;

  always_comb begin
    clr_w = '0;
    set_w = '0;
    dis_w = '0;
    if (wr_en_i) begin
      unique case (reg_ofs_e'(wr_ofs_i))
        OFS_SRC:   clr_w = wdata_i;
        OFS_ENSET: set_w = wdata_i;
        OFS_ENCLR: dis_w = wdata_i;
        default:   ;
      endcase
    end
  end

  // Sticky source: new events override a simultaneous clear.
  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= (src_q & ~clr_w) | evt_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q | set_w) & ~dis_w;
  end

  assign src_o = src_q;
  assign en_o  = en_q;
  assign res_o = src_q & en_q;
  assign any_o = |res_o;

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((src_q & $past(evt_i)) == $past(evt_i)));                 // R8
  AST_NO_SPURIOUS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((src_q & ~$past(src_q | evt_i)) == '0));                  // R1
  AST_SRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w != '0) |=> ((src_q & $past(clr_w & ~evt_i)) == '0));         // R2
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w != '0) |=> ((en_q & $past(set_w)) == $past(set_w)));         // R3
  AST_EN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_w != '0) |=> ((en_q & $past(dis_w)) == '0));                   // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w == '0 && dis_w == '0) |=> $stable(en_q));                    // R3
endmodule

// File: rtl/irq_blk_gate.sv
`timescale 1ns/1ps
// Block-enable register and per-group output gating.
module irq_blk_gate #(
  parameter int NUM_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [NUM_GROUPS-1:0] wdata_i,
  input  logic [NUM_GROUPS-1:0] any_i,
  output logic [NUM_GROUPS-1:0] blk_o,
  output logic [NUM_GROUPS-1:0] irq_o
);
  logic [NUM_GROUPS-1:0] blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       blk_q <= '0;
    else if (wr_en_i) blk_q <= wdata_i;
  end

  assign blk_o = blk_q;
  assign irq_o = blk_q & any_i;
endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator #(
  parameter int NUM_GROUPS      = 4,
  parameter int PORTS_PER_GROUP = 4,
  parameter int ADDR_W          = 8,
  localparam int GROUP_W  = PORTS_PER_GROUP * 8,
  localparam int NUM_PINS = NUM_GROUPS * GROUP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_evt_i,
  input  logic                  bus_we_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [31:0]           bus_wdata_i,
  output logic [31:0]           bus_rdata_o,
  output logic [NUM_GROUPS-1:0] irq_o
);
  import irq_agg_pkg::*;

  localparam logic [ADDR_W-1:0] BLK_ADDR = ADDR_W'(NUM_GROUPS * 4);

  initial begin
    if (GROUP_W > BUS_W)  $error("group wider than bus");
    if (NUM_GROUPS > BUS_W) $error("too many groups");
    if ((1 << ADDR_W) <= NUM_GROUPS * 4) $error("address too narrow");
  end

  logic [NUM_GROUPS-1:0][GROUP_W-1:0] grp_evt, src, en, res;
  logic [NUM_GROUPS-1:0]              any, blk;
  logic [ADDR_W-3:0]                  grp_sel;
  logic [1:0]                         ofs;
  logic                               in_groups, blk_hit;
  logic                               unused_wdata;

  assign grp_sel      = bus_addr_i[ADDR_W-1:2];
  assign ofs          = bus_addr_i[1:0];
  assign in_groups    = (bus_addr_i < BLK_ADDR);
  assign blk_hit      = (bus_addr_i == BLK_ADDR);
  assign unused_wdata = ^bus_wdata_i;

  irq_port_map #(
    .NUM_GROUPS(NUM_GROUPS),
    .PORTS_PER_GROUP(PORTS_PER_GROUP)
  ) u_map (
    .pin_evt_i(pin_evt_i),
    .grp_evt_o(grp_evt)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = bus_we_i && in_groups && (grp_sel == (ADDR_W-2)'(g));

    irq_group #(.GROUP_W(GROUP_W)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (grp_evt[g]),
      .wr_en_i (hit),
      .wr_ofs_i(ofs),
      .wdata_i (bus_wdata_i[GROUP_W-1:0]),
      .src_o   (src[g]),
      .en_o    (en[g]),
      .res_o   (res[g]),
      .any_o   (any[g])
    );

    AST_IRQ_NEEDS_BLK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |-> blk[g]);                                              // R6
    AST_IRQ_NEEDS_RES: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |-> (src[g] & en[g]) != '0);                              // R6
    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      (blk[g] && ((src[g] & en[g]) != '0)) |-> irq_o[g]);                // R6
  end

  irq_blk_gate #(.NUM_GROUPS(NUM_GROUPS)) u_blk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en_i(bus_we_i && blk_hit),
    .wdata_i(bus_wdata_i[NUM_GROUPS-1:0]),
    .any_i  (any),
    .blk_o  (blk),
    .irq_o  (irq_o)
  );

  // Combinational read mux.
  always_comb begin
    bus_rdata_o = '0;
    if (blk_hit) begin
      bus_rdata_o[NUM_GROUPS-1:0] = blk;
    end else if (in_groups) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (grp_sel == (ADDR_W-2)'(g)) begin
          unique case (reg_ofs_e'(ofs))
            OFS_SRC:   bus_rdata_o[GROUP_W-1:0] = src[g];
            OFS_ENSET: bus_rdata_o[GROUP_W-1:0] = en[g];
            OFS_ENCLR: bus_rdata_o = '0;
            OFS_RES:   bus_rdata_o[GROUP_W-1:0] = res[g];
            default:   bus_rdata_o = '0;
          endcase
        end
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) && !rst_n |-> irq_o == '0);                           // R9
endmodule

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
  localparam int NG = 4;
  localparam int PPG = 4;
  localparam int NP = NG * PPG * 8;
  localparam int NV = 30;

  // kind: 0 write, 1 read-check, 2 event on group (addr=group, data=bits), 3 irq check
  localparam logic [73:0] VEC [0:NV-1] = '{
    {2'd2, 8'd0,  32'h0000_00F1, 32'h0},            // R1 event g0
    {2'd1, 8'd0,  32'h0,         32'h0000_00F1},    // R1
    {2'd1, 8'd3,  32'h0,         32'h0},            // R5 nothing enabled
    {2'd3, 8'd0,  32'h0,         32'h0},            // R6
    {2'd0, 8'd1,  32'h0000_0011, 32'h0},
    {2'd1, 8'd1,  32'h0,         32'h0000_0011},    // R3
    {2'd0, 8'd1,  32'h0000_0100, 32'h0},
    {2'd1, 8'd1,  32'h0,         32'h0000_0111},    // R3 zeros keep
    {2'd1, 8'd3,  32'h0,         32'h0000_0011},    // R5
    {2'd3, 8'd0,  32'h0,         32'h0},            // R6 block off
    {2'd0, 8'd16, 32'h0000_0001, 32'h0},
    {2'd1, 8'd16, 32'h0,         32'h0000_0001},    // R10
    {2'd3, 8'd0,  32'h0,         32'h0000_0001},    // R6
    {2'd0, 8'd0,  32'h0000_0010, 32'h0},
    {2'd1, 8'd0,  32'h0,         32'h0000_00E1},    // R2
    {2'd0, 8'd0,  32'h0000_0080, 32'h0},
    {2'd1, 8'd0,  32'h0,         32'h0000_0061},    // R2 not enabled
    {2'd0, 8'd0,  32'h0000_0000, 32'h0},
    {2'd1, 8'd0,  32'h0,         32'h0000_0061},    // R2 zero write
    {2'd0, 8'd2,  32'h0000_0001, 32'h0},
    {2'd1, 8'd1,  32'h0,         32'h0000_0110},    // R4
    {2'd1, 8'd2,  32'h0,         32'h0},            // R4 reads zero
    {2'd3, 8'd0,  32'h0,         32'h0},            // R6 result gone
    {2'd2, 8'd1,  32'hAB00_0000, 32'h0},
    {2'd1, 8'd4,  32'h0,         32'hAB00_0000},    // R7
    {2'd0, 8'd5,  32'h8000_0000, 32'h0},
    {2'd0, 8'd16, 32'h0000_0003, 32'h0},
    {2'd3, 8'd0,  32'h0,         32'h0000_0002},    // R6
    {2'd1, 8'd7,  32'h0,         32'h8000_0000},    // R5
    {2'd1, 8'd17, 32'h0,         32'h0}             // R10 unmapped
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_evt = '0;
  logic          we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NG-1:0] irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_aggregator #(.NUM_GROUPS(NG), .PORTS_PER_GROUP(PPG), .ADDR_W(8)) u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .pin_evt_i(pin_evt), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic evt(input int g, input logic [31:0] bits);
    @(negedge clk); pin_evt[g*32 +: 32] = bits;
    @(negedge clk); pin_evt = '0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    #1 chk("R9 irq", 32'(irq), 32'h0);
    for (int a = 0; a <= 16; a++) rd("R9 regs", 8'(a), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] k; logic [7:0] a; logic [31:0] d, e;
      {k, a, d, e} = VEC[i];
      case (k)
        2'd0: wr(a, d);
        2'd1: rd($sformatf("vec%0d", i), a, e);
        2'd2: evt(int'(a), d);
        default: begin @(negedge clk); #1 chk($sformatf("R6 vec%0d", i), 32'(irq), e); end
      endcase
    end

    // R8: event and clear on the same bit in the same cycle
    evt(2, 32'h8);
    @(negedge clk); pin_evt[2*32 + 3] = 1'b1; we = 1'b1; addr = 8'd8; wdata = 32'h8;
    @(negedge clk); pin_evt = '0; we = 1'b0; wdata = '0;
    rd("R8 event wins", 8'd8, 32'h8);
    wr(8'd8, 32'h8);
    rd("R2 clear after", 8'd8, 32'h0);

    // R7 single pin: group 3, port 2, pin 5 -> bit 21
    @(negedge clk); pin_evt[(3*PPG + 2)*8 + 5] = 1'b1;
    @(negedge clk); pin_evt = '0;
    rd("R7 single pin", 8'd12, 32'h0020_0000);
    rd("R1 sticky", 8'd12, 32'h0020_0000);

    // R6 group 3: enable bit then block enable
    wr(8'd13, 32'h0020_0000);
    wr(8'd16, 32'h8);
    @(negedge clk); #1 chk("R6 g3", 32'(irq), 32'h8);
    wr(8'd12, 32'h0020_0000);
    @(negedge clk); #1 chk("R6 g3 cleared", 32'(irq), 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule